// File: doc/BRIEF.md
# Character raster timing generator

This block produces the beam timing for a display built from character cells. A horizontal character counter sets the line length, the horizontal sync pulse and the active part of each line. A vertical section counts scan lines within a character row, counts the rows themselves, and then adds a separately programmed run of adjust scan lines before the frame starts again. From these counts the block derives vertical sync, a vertical-blanking flag, the current raster line within the row and a display-enable signal. Display enable can be delayed by zero, one or two character clocks, or switched off.

Alongside the timing, the block walks a 14-bit refresh memory address through the character store. Each frame starts at a programmed start address. Each displayed character moves the address on by one. Every scan line of a row re-reads the same span of addresses, and each new row starts one displayed-line width further on. All timing values are static inputs, held steady by the surrounding logic. Every counter moves only on cycles where the character-clock enable is high.

Top module: `crt_timing`

## Requirements
- R1: The horizontal count `h` runs 0 to `h_total` and wraps to 0, so a line lasts `h_total`+1 character ticks. A tick is a clock edge with `char_ce` high. On an edge with `char_ce` low, no output changes.
- R2: `disp_en` with `de_skew`=0 is high exactly when `h` < `h_disp` and `vblank` is low.
- R3: `hsync` is high for `h` in [`hs_pos`, `hs_pos`+W), where W is `hs_width` and a value of 0 gives W=16.
- R4: A frame is `v_total`+1 rows of `max_scan`+1 scan lines, followed by `v_adj` adjust lines. `raster` counts 0..`max_scan` within a row and 0..`v_adj`-1 in the adjust lines. When `v_adj`=0, no adjust lines are inserted.
- R5: `vblank` is high while the row index (0-based) is at least `v_disp`, and during all adjust lines.
- R6: `vsync` rises at the first scan line of row `vs_pos` and stays high for V whole scan lines, where V is `vs_width` and 0 gives V=16. The count of V lines carries on across a frame wrap.
- R7: `de_skew` codes 0, 1 and 2 delay the undelayed display enable of R2 by that many character ticks. Code 3 holds `disp_en` low.
- R8: `mem_addr` equals (row start + min(`h`, `h_disp`)) modulo 2^14. Row start is the frame base plus `h_disp` times the row index, and it is taken as `v_total`+1 during the adjust lines. The frame base is `start_addr` for every frame after the first.
- R9: A synchronous reset, which takes priority over `char_ce`, clears all counters. After reset, `mem_addr` and `raster` read 0 and the first frame uses base address 0. The skew delay stages read 0 until they are refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_ce | input | 1 | Character-clock enable |
| h_total | input | 8 | Characters per line minus one |
| h_disp | input | 8 | Displayed characters per line |
| hs_pos | input | 8 | Character position where horizontal sync starts |
| hs_width | input | 4 | Horizontal sync width in characters, 0 means 16 |
| v_total | input | 7 | Rows per frame minus one |
| v_adj | input | 5 | Extra adjust scan lines per frame |
| v_disp | input | 7 | Displayed rows |
| vs_pos | input | 7 | Row where vertical sync starts |
| vs_width | input | 4 | Vertical sync width in scan lines, 0 means 16 |
| max_scan | input | 5 | Scan lines per row minus one |
| start_addr | input | 14 | Refresh address at frame start |
| de_skew | input | 2 | Display-enable delay: 0, 1, 2 ticks, 3 disables |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| disp_en | output | 1 | Skewed display enable |
| mem_addr | output | 14 | Refresh memory address |
| raster | output | 5 | Scan line within row or adjust region |
| vblank | output | 1 | Vertical blanking flag |

## Verification
A wrong horizontal count shows up as a shifted `hsync` or `disp_en` edge within the same line. A wrong row or scan count shows up on `raster` and `vblank` at the next line boundary. A wrong row-start register does not show until the next line reload of `mem_addr`. A wrong frame-wrap decision shows only one frame later, as a bad base address, so every configuration runs for more than two frames. A stuck sync down-counter either cuts `vsync` short or stretches it across the frame wrap. Stalled ticks are compared against the previous sample, so any state that moves without `char_ce` is caught on the very next cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int CRT_HW  = 8;
    localparam int CRT_VW  = 7;
    localparam int CRT_RW  = 5;
    localparam int CRT_AW  = 14;
    localparam int CRT_SWW = 4;
    localparam int CRT_SKD = 2;

    typedef enum logic [1:0] {
        SKEW_NONE = 2'd0,
        SKEW_ONE  = 2'd1,
        SKEW_TWO  = 2'd2,
        SKEW_OFF  = 2'd3
    } skew_e;
endpackage

// File: rtl/crt_hcount.sv
module crt_hcount #(
    parameter int HW  = 8,
    parameter int SWW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    input  logic [HW-1:0]  h_total,
    input  logic [HW-1:0]  h_disp,
    input  logic [HW-1:0]  hs_pos,
    input  logic [SWW-1:0] hs_width,
    output logic [HW-1:0]  hcnt,
    output logic           line_end,
    output logic           h_active,
    output logic           hsync
);
    typedef struct packed {
        logic [HW-1:0]  cnt;
        logic [SWW-1:0] hs_left;
    } hst_t;

    hst_t q, d;
    logic hs_start;
    logic [SWW-1:0] width_m1;

    always_comb begin
        d        = q;
        line_end = (q.cnt == h_total);
        hs_start = (q.cnt == hs_pos);
        width_m1 = hs_width - SWW'(1);
        if (ce) begin
            d.cnt = line_end ? '0 : q.cnt + HW'(1);
            if (hs_start) begin
                d.hs_left = width_m1;
            end else if (q.hs_left != '0) begin
                d.hs_left = q.hs_left - SWW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hcnt     = q.cnt;
    assign h_active = (q.cnt < h_disp);
    assign hsync    = hs_start || (q.hs_left != '0);

    // R1: the horizontal count holds on a stalled edge
    p_stall_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q.cnt));

    // R3: a new sync pulse can only begin at the programmed position
    p_hsync_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (q.cnt == hs_pos));
endmodule

// File: rtl/crt_vcount.sv
module crt_vcount #(
    parameter int VW  = 7,
    parameter int RW  = 5,
    parameter int SWW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    input  logic           line_end,
    input  logic [VW-1:0]  v_total,
    input  logic [RW-1:0]  v_adj,
    input  logic [VW-1:0]  v_disp,
    input  logic [VW-1:0]  vs_pos,
    input  logic [SWW-1:0] vs_width,
    input  logic [RW-1:0]  max_scan,
    output logic [RW-1:0]  raster,
    output logic           row_end,
    output logic           frame_end,
    output logic           v_active,
    output logic           vblank,
    output logic           vsync
);
    typedef struct packed {
        logic [VW-1:0]  row;
        logic [RW-1:0]  scan;
        logic           adj;
        logic [SWW-1:0] vs_left;
    } vst_t;

    vst_t q, d;
    logic step;
    logic vs_start;
    logic adj_last;
    logic [RW:0] scan_p1;

    always_comb begin
        d         = q;
        step      = ce && line_end;
        row_end   = !q.adj && (q.scan == max_scan);
        scan_p1   = {1'b0, q.scan} + (RW+1)'(1);
        adj_last  = q.adj && (scan_p1 == {1'b0, v_adj});
        frame_end = (row_end && (q.row == v_total) && (v_adj == '0)) || adj_last;
        vs_start  = !q.adj && (q.row == vs_pos) && (q.scan == '0);
        if (step) begin
            if (frame_end) begin
                d.row  = '0;
                d.scan = '0;
                d.adj  = 1'b0;
            end else if (row_end) begin
                d.scan = '0;
                if (q.row == v_total) begin
                    d.adj = 1'b1;
                end else begin
                    d.row = q.row + VW'(1);
                end
            end else begin
                d.scan = q.scan + RW'(1);
            end
            if (vs_start) begin
                d.vs_left = vs_width - SWW'(1);
            end else if (q.vs_left != '0) begin
                d.vs_left = q.vs_left - SWW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign raster   = q.scan;
    assign vblank   = q.adj || (q.row >= v_disp);
    assign v_active = !vblank;
    assign vsync    = vs_start || (q.vs_left != '0);

    // R4: inside a character row the scan line never passes the last line
    p_scan_bound_r4: assert property (@(posedge clk) disable iff (rst)
        !q.adj |-> (q.scan <= max_scan));

    // R4: the adjust region never outlasts its programmed length
    p_adj_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q.adj |-> (q.scan < v_adj));

    // R6: vertical sync only changes at a scan-line boundary
    p_vsync_edge_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(vsync) |-> $past(step));
endmodule

// File: rtl/crt_addr.sv
module crt_addr #(
    parameter int AW = 14,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          line_end,
    input  logic          row_end,
    input  logic          frame_end,
    input  logic          h_active,
    input  logic [HW-1:0] h_disp,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] mem_addr
);
    typedef struct packed {
        logic [AW-1:0] ma;
        logic [AW-1:0] row_start;
    } ast_t;

    ast_t q, d;
    logic [AW-1:0] stride;
    logic [AW-1:0] next_row;

    always_comb begin
        d        = q;
        stride   = AW'(h_disp);
        next_row = q.row_start + stride;
        if (ce) begin
            if (line_end) begin
                if (frame_end) begin
                    d.ma        = start_addr;
                    d.row_start = start_addr;
                end else if (row_end) begin
                    d.ma        = next_row;
                    d.row_start = next_row;
                end else begin
                    d.ma = q.row_start;
                end
            end else if (h_active) begin
                d.ma = q.ma + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_addr = q.ma;

    // R8: outside the displayed span the address holds until the line reload
    p_ma_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (ce && !line_end && !h_active) |=> $stable(q.ma));

    // R8: the first character of every line reads the row start
    p_ma_line_start_r8: assert property (@(posedge clk) disable iff (rst)
        (ce && line_end && !frame_end) |=> (q.ma == q.row_start));
endmodule

// File: rtl/crt_skew.sv
module crt_skew #(
    parameter int DEPTH = 2,
    parameter int SKW   = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ce,
    input  logic           de_in,
    input  logic [SKW-1:0] skew,
    output logic           de_out
);
    localparam int NT = 2 ** SKW;

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } kst_t;

    kst_t q, d;
    logic [NT-1:0] tap;

    always_comb begin
        d = q;
        if (ce) begin
            d.pipe[0] = de_in;
            for (int i = 1; i < DEPTH; i++) begin
                d.pipe[i] = q.pipe[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NT; g++) begin : g_tap
        if (g == 0) begin : g_direct
            assign tap[g] = de_in;
        end else if (g <= DEPTH) begin : g_delayed
            assign tap[g] = q.pipe[g-1];
        end else begin : g_off
            assign tap[g] = 1'b0;
        end
    end

    assign de_out = tap[skew];
endmodule

// File: rtl/crt_timing.sv
module crt_timing
    import crt_pkg::*;
#(
    parameter int HW  = CRT_HW,
    parameter int VW  = CRT_VW,
    parameter int RW  = CRT_RW,
    parameter int AW  = CRT_AW,
    parameter int SWW = CRT_SWW,
    parameter int SKD = CRT_SKD
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           char_ce,
    input  logic [HW-1:0]  h_total,
    input  logic [HW-1:0]  h_disp,
    input  logic [HW-1:0]  hs_pos,
    input  logic [SWW-1:0] hs_width,
    input  logic [VW-1:0]  v_total,
    input  logic [RW-1:0]  v_adj,
    input  logic [VW-1:0]  v_disp,
    input  logic [VW-1:0]  vs_pos,
    input  logic [SWW-1:0] vs_width,
    input  logic [RW-1:0]  max_scan,
    input  logic [AW-1:0]  start_addr,
    input  logic [1:0]     de_skew,
    output logic           hsync,
    output logic           vsync,
    output logic           disp_en,
    output logic [AW-1:0]  mem_addr,
    output logic [RW-1:0]  raster,
    output logic           vblank
);
    logic [HW-1:0] hcnt;
    logic line_end, h_active;
    logic row_end, frame_end, v_active;
    logic de_raw;

    crt_hcount #(.HW(HW), .SWW(SWW)) u_h (
        .clk(clk), .rst(rst), .ce(char_ce),
        .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos), .hs_width(hs_width),
        .hcnt(hcnt), .line_end(line_end), .h_active(h_active), .hsync(hsync)
    );

    crt_vcount #(.VW(VW), .RW(RW), .SWW(SWW)) u_v (
        .clk(clk), .rst(rst), .ce(char_ce), .line_end(line_end),
        .v_total(v_total), .v_adj(v_adj), .v_disp(v_disp), .vs_pos(vs_pos),
        .vs_width(vs_width), .max_scan(max_scan),
        .raster(raster), .row_end(row_end), .frame_end(frame_end),
        .v_active(v_active), .vblank(vblank), .vsync(vsync)
    );

    crt_addr #(.AW(AW), .HW(HW)) u_a (
        .clk(clk), .rst(rst), .ce(char_ce), .line_end(line_end),
        .row_end(row_end), .frame_end(frame_end), .h_active(h_active),
        .h_disp(h_disp), .start_addr(start_addr), .mem_addr(mem_addr)
    );

    assign de_raw = h_active && v_active;

    crt_skew #(.DEPTH(SKD), .SKW(2)) u_k (
        .clk(clk), .rst(rst), .ce(char_ce), .de_in(de_raw),
        .skew(de_skew), .de_out(disp_en)
    );

    // R5: no character is enabled while the frame is vertically blanked
    p_vblank_dark_r5: assert property (@(posedge clk) disable iff (rst)
        vblank |-> !de_raw);

    // R7: the off code keeps display enable low
    p_skew_off_r7: assert property (@(posedge clk) disable iff (rst)
        (de_skew == SKEW_OFF) |-> !disp_en);

    // R2: with no skew the enable follows the horizontal and vertical windows
    p_de_window_r2: assert property (@(posedge clk) disable iff (rst)
        (de_skew == SKEW_NONE && disp_en) |-> (h_active && !vblank));

    // R1: a stalled edge leaves the refresh address alone
    p_stall_addr_r1: assert property (@(posedge clk) disable iff (rst)
        !char_ce |=> $stable(mem_addr));
endmodule

// File: tb/sim_crt_timing.sv
module sim_crt_timing;
    localparam int PERIOD = 10;

    typedef struct {
        int r0, r1, r2, hw, r4, r5, r6, r7, vw, r9, start, skew, cemode;
    } cfg_t;

    typedef struct {
        int  t;
        bit  stall;
        bit  hs, vs, de, vb;
        int  ma, ras;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_ce = 1'b0;
    logic [7:0] h_total = '0, h_disp = '0, hs_pos = '0;
    logic [3:0] hs_width = '0, vs_width = '0;
    logic [6:0] v_total = '0, v_disp = '0, vs_pos = '0;
    logic [4:0] v_adj = '0, max_scan = '0;
    logic [13:0] start_addr = '0;
    logic [1:0] de_skew = '0;
    logic hsync, vsync, disp_en, vblank;
    logic [13:0] mem_addr;
    logic [4:0] raster;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    cfg_t cur;
    bit driving = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #(PERIOD/2) clk = ~clk;

    crt_timing u0 (
        .clk(clk), .rst(rst), .char_ce(char_ce),
        .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos), .hs_width(hs_width),
        .v_total(v_total), .v_adj(v_adj), .v_disp(v_disp), .vs_pos(vs_pos),
        .vs_width(vs_width), .max_scan(max_scan), .start_addr(start_addr),
        .de_skew(de_skew), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .mem_addr(mem_addr), .raster(raster), .vblank(vblank)
    );

    function automatic bit is_vb(cfg_t c, int t);
        int hl = c.r0 + 1;
        int rl = c.r9 + 1;
        int body = (c.r4 + 1) * rl;
        int f = body + c.r5;
        int lf = (t / hl) % f;
        bit adj = (lf >= body);
        int row = adj ? c.r4 : lf / rl;
        return adj || (row >= c.r6);
    endfunction

    function automatic bit raw_de(cfg_t c, int t);
        return ((t % (c.r0 + 1)) < c.r1) && !is_vb(c, t);
    endfunction

    function automatic exp_t calc(cfg_t c, int t);
        exp_t e;
        int hl = c.r0 + 1;
        int ln = t / hl;
        int h = t % hl;
        int rl = c.r9 + 1;
        int body = (c.r4 + 1) * rl;
        int f = body + c.r5;
        int fi = ln / f;
        int lf = ln % f;
        bit adj = (lf >= body);
        int row = adj ? c.r4 : lf / rl;
        int base = (fi == 0) ? 0 : c.start;
        int rs = base + (adj ? (c.r4 + 1) : row) * c.r1;
        int hw = (c.hw == 0) ? 16 : c.hw;
        int vw = (c.vw == 0) ? 16 : c.vw;
        int off = ln - c.r7 * rl;
        e.t = t;
        e.stall = 1'b0;
        e.ras = adj ? (lf - body) : (lf % rl);
        e.ma = (rs + ((h < c.r1) ? h : c.r1)) & 16'h3FFF;
        e.hs = (h >= c.r2) && (h < c.r2 + hw);
        e.vs = (off >= 0) && ((off % f) < vw);
        e.vb = is_vb(c, t);
        if (c.skew == 3) e.de = 1'b0;
        else if (t >= c.skew) e.de = raw_de(c, t - c.skew);
        else e.de = 1'b0;
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv, int t);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s tick %0d actual %0d expected %0d", req, what, t, act, expv);
        end
    endtask

    // monitor: pops expected items and compares them with the ports
    initial begin : monitor
        logic ph, pv, pd, pb;
        logic [13:0] pm;
        logic [4:0] pr;
        ph = 0; pv = 0; pd = 0; pb = 0; pm = 0; pr = 0;
        forever begin
            @(negedge clk);
            #(PERIOD/4);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.stall) begin
                    chk({hsync, vsync, disp_en, vblank, mem_addr, raster} ==
                        {ph, pv, pd, pb, pm, pr}, "R1", "stall hold",
                        int'(mem_addr), int'(pm), e.t);
                end
                if (e.t == 0) begin
                    chk(mem_addr == 14'd0, "R9", "reset address", int'(mem_addr), 0, e.t);
                    chk(raster == 5'd0, "R9", "reset raster", int'(raster), 0, e.t);
                end
                chk(hsync == e.hs, "R3", "hsync", int'(hsync), int'(e.hs), e.t);
                chk(vsync == e.vs, "R6", "vsync", int'(vsync), int'(e.vs), e.t);
                chk(vblank == e.vb, "R5", "vblank", int'(vblank), int'(e.vb), e.t);
                chk(int'(raster) == e.ras, "R4", "raster", int'(raster), e.ras, e.t);
                chk(int'(mem_addr) == e.ma, "R8", "address", int'(mem_addr), e.ma, e.t);
                if (cur.skew == 0)
                    chk(disp_en == e.de, "R2", "display enable", int'(disp_en), int'(e.de), e.t);
                else
                    chk(disp_en == e.de, "R7", "skewed enable", int'(disp_en), int'(e.de), e.t);
            end
            ph = hsync; pv = vsync; pd = disp_en; pb = vblank; pm = mem_addr; pr = raster;
        end
    end

    // driver: applies one configuration and pushes the expected outputs per cycle
    task automatic run_cfg(cfg_t c, int nticks);
        int t = 0;
        bit last_ce = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        char_ce = 1'b1;
        cur = c;
        h_total = 8'(c.r0); h_disp = 8'(c.r1); hs_pos = 8'(c.r2); hs_width = 4'(c.hw);
        v_total = 7'(c.r4); v_adj = 5'(c.r5); v_disp = 7'(c.r6); vs_pos = 7'(c.r7);
        vs_width = 4'(c.vw); max_scan = 5'(c.r9); start_addr = 14'(c.start);
        de_skew = 2'(c.skew);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        while (t < nticks) begin
            exp_t e;
            e = calc(c, t);
            e.stall = !last_ce;
            q.push_back(e);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            char_ce = (c.cemode == 0) ? 1'b1 : (lfsr[1:0] != 2'b00);
            last_ce = char_ce;
            if (char_ce) t++;
            @(negedge clk);
        end
        #(PERIOD/2);
    endtask

    initial begin : watchdog
        #(PERIOD * 200000);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        cfg_t c;
        // R8 address wrap at 2^14, R4 adjust lines, no skew
        c = '{r0:9, r1:6, r2:7, hw:2, r4:4, r5:2, r6:3, r7:3, vw:2, r9:2,
              start:16'h3FFE, skew:0, cemode:1};
        run_cfg(c, 430);
        // R3 and R6 widths of 0 mean 16, vsync crosses frame wrap, no adjust, skew 1
        c = '{r0:20, r1:10, r2:4, hw:0, r4:9, r5:0, r6:10, r7:8, vw:0, r9:1,
              start:16'h0123, skew:1, cemode:1};
        run_cfg(c, 1060);
        // R7 skew of two, short rows, one adjust line
        c = '{r0:7, r1:5, r2:5, hw:3, r4:2, r5:1, r6:2, r7:1, vw:1, r9:1,
              start:16'h0100, skew:2, cemode:0};
        run_cfg(c, 180);
        // R7 skew off, vsync at row 0, R9 reset from a running state
        c = '{r0:5, r1:3, r2:3, hw:1, r4:1, r5:0, r6:1, r7:0, vw:1, r9:0,
              start:16'h0010, skew:3, cemode:1};
        run_cfg(c, 60);
        c.skew = 0;
        run_cfg(c, 60);
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule